// File: doc/BRIEF.md
# Banked Data-Memory Address Former

This block builds the 12-bit data-memory address for an instruction that names its operand directly. The instruction supplies an 8-bit file address and a one-bit selector. When the selector is 1, the upper four address bits come from a bank register held inside the block. When it is 0, the access window is used instead. That window joins the lowest 128 general-purpose bytes with the top 128 bytes of the space, where the special-function registers live.

The 4 KB space is split into sixteen banks of 256 bytes. A load command writes the bank register. It is 8 bits wide as seen from outside, but only its low nibble is kept. The block also raises a flag whenever the address it produces falls in the special-function region, which runs from 0xF80 to 0xFFF. The RAM array, the register contents and instruction fetch are handled by neighbouring logic.

Top module: `dmem_addr_former`

## Requirements
- R1: After a synchronous active-low reset, the bank register reads back as 0x00.
- R2: A cycle with `bank_wr` high loads `bank_wdata[3:0]` into the bank register. From the next cycle on, `bank_q` equals `{4'h0, bank_wdata[3:0]}`, so the upper four written bits read back as zero and have no effect on any address.
- R3: In a cycle with `bank_wr` low, the bank register keeps its value.
- R4: When `bank_sel` is 1 (banked), `phys_addr` equals `{bank_q[3:0], file_addr}`. Bank n therefore covers n*0x100 to n*0x100+0xFF.
- R5: When `bank_sel` is 0 and `file_addr[7]` is 0, `phys_addr` equals `{4'h0, file_addr}` (0x000 to 0x07F), whatever the bank register holds.
- R6: When `bank_sel` is 0 and `file_addr[7]` is 1, `phys_addr` equals `{4'hF, file_addr}` (0xF80 to 0xFFF), whatever the bank register holds.
- R7: `sfr_hit` is 1 exactly when `phys_addr` is 0xF80 or above, in either mode.
- R8: The working-register location 0xFE8 can be reached in two ways: with `bank_sel`=0 and file address 0xE8, or with `bank_sel`=1, bank 15 and file address 0xE8. Both give `sfr_hit`=1.
- R9: `phys_addr` and `sfr_hit` follow `file_addr` and `bank_sel` in the same cycle, with no register in between. A bank load takes effect in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_wr | input | 1 | Load the bank register this cycle |
| bank_wdata | input | 8 | Literal to load; only bits 3:0 are kept |
| file_addr | input | 8 | File address field of the instruction |
| bank_sel | input | 1 | 1 = banked through the bank register, 0 = access window |
| phys_addr | output | 12 | Resolved data-memory address |
| sfr_hit | output | 1 | Resolved address lies in 0xF80..0xFFF |
| bank_q | output | 8 | Bank register read-back, upper nibble always zero |

## Verification
Several relations are checked on every cycle:
- the bank register's reset value and its one-cycle load (R1, R2, R3);
- the three mapping rules (R4, R5, R6), stated against the ports;
- the agreement between the region flag and the address (R7).

Some behaviour shows only through the bench's scenarios. One is that every one of the sixteen banks is reachable. Another is that access-mode addresses do not move when the bank register changes. The bench also confirms the two ways of reaching 0xFE8 and the exact edges 0x7F/0x80 and 0xF7F/0xF80.

// File: rtl/dmem_pkg.sv
// Package: shared widths and the selector encoding for the address former.
// Assumes an 8-bit file field and a 4-bit bank number (12-bit space).
package dmem_pkg;
    localparam int unsigned FILE_W   = 8;
    localparam int unsigned BANK_W   = 4;
    localparam int unsigned BSR_W    = 8;
    localparam int unsigned ADDR_W   = FILE_W + BANK_W;
    localparam int unsigned SFR_BASE = 32'hF80;

    // Selector bit from the instruction word.
    typedef enum logic {
        SEL_ACCESS = 1'b0,
        SEL_BANKED = 1'b1
    } addr_sel_e;
endpackage

// File: rtl/bank_select_reg.sv
// Bank select register. Stores only the low USED_W bits of a REG_W-bit
// write and presents the rest as zeros. Synchronous active-low reset to 0.
module bank_select_reg #(
    parameter int unsigned REG_W  = 8,
    parameter int unsigned USED_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    output logic [USED_W-1:0] bank,
    output logic [REG_W-1:0]  rdata
);
    logic [USED_W-1:0] bank_r;

    // Hold the bank number; load the kept bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_r <= '0;
        else if (wr_en)
            bank_r <= wdata[USED_W-1:0];
    end

    assign bank = bank_r;

    generate
        if (REG_W > USED_W) begin : g_pad
            logic unused_hi_bits;
            // Upper written bits are dropped; read back as zero.
            assign unused_hi_bits = ^wdata[REG_W-1:USED_W];
            assign rdata = {{(REG_W-USED_W){1'b0}}, bank_r};
        end else begin : g_nopad
            assign rdata = bank_r;
        end
    endgenerate
endmodule

// File: rtl/addr_mapper.sv
// Address mapper. In banked mode, prepends the bank number to the file
// address. In access mode, the top bit of the file field picks the first
// or the last bank, which splices low RAM with the top register block.
// Purely combinational.
module addr_mapper
    import dmem_pkg::*;
#(
    parameter int unsigned F_W = 8,
    parameter int unsigned B_W = 4
) (
    input  addr_sel_e         sel,
    input  logic [F_W-1:0]    file_addr,
    input  logic [B_W-1:0]    bank,
    output logic [F_W+B_W-1:0] addr
);
    logic [B_W-1:0] upper;

    // Choose the upper address bits for the selected mode.
    always_comb begin
        if (sel == SEL_BANKED)
            upper = bank;
        else
            upper = {B_W{file_addr[F_W-1]}};
    end

    assign addr = {upper, file_addr};
endmodule

// File: rtl/sfr_region_detect.sv
// Region detector. Flags any address at or above the register-block base.
// Assumes the base lies inside the address range.
module sfr_region_detect #(
    parameter int unsigned A_W  = 12,
    parameter int unsigned BASE = 32'hF80
) (
    input  logic [A_W-1:0] addr,
    output logic           hit
);
    localparam logic [A_W-1:0] BASE_A = A_W'(BASE);

    // Compare against the region base.
    always_comb hit = (addr >= BASE_A);
endmodule

// File: rtl/dmem_addr_former.sv
// Top level: forms the data-memory address for direct operands.
// It holds the bank register, maps the address by mode and flags the
// register block. Address outputs are combinational from the inputs and
// the registered bank.
module dmem_addr_former
    import dmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_wr,
    input  logic [BSR_W-1:0]  bank_wdata,
    input  logic [FILE_W-1:0] file_addr,
    input  logic              bank_sel,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              sfr_hit,
    output logic [BSR_W-1:0]  bank_q
);
    logic [BANK_W-1:0] bank_num;
    addr_sel_e         sel_e;

    // Decode the selector bit to the mode type.
    always_comb sel_e = addr_sel_e'(bank_sel);

    bank_select_reg #(.REG_W(BSR_W), .USED_W(BANK_W)) u_bsr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bank_wr),
        .wdata (bank_wdata),
        .bank  (bank_num),
        .rdata (bank_q)
    );

    addr_mapper #(.F_W(FILE_W), .B_W(BANK_W)) u_map (
        .sel       (sel_e),
        .file_addr (file_addr),
        .bank      (bank_num),
        .addr      (phys_addr)
    );

    sfr_region_detect #(.A_W(ADDR_W), .BASE(SFR_BASE)) u_sfr (
        .addr (phys_addr),
        .hit  (sfr_hit)
    );
endmodule

// File: rtl/dmem_addr_former_chk.sv
// Checker bound to dmem_addr_former: cycle-by-cycle port relations.
module dmem_addr_former_chk
    import dmem_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bank_wr,
    input logic [BSR_W-1:0]  bank_wdata,
    input logic [FILE_W-1:0] file_addr,
    input logic              bank_sel,
    input logic [ADDR_W-1:0] phys_addr,
    input logic              sfr_hit,
    input logic [BSR_W-1:0]  bank_q
);
    // R1
    bank_reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> bank_q == '0);
    // R2
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |=> bank_q == {{(BSR_W-BANK_W){1'b0}}, $past(bank_wdata[BANK_W-1:0])});
    // R3
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_wr |=> $stable(bank_q));
    // R4
    banked_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sel |-> phys_addr == {bank_q[BANK_W-1:0], file_addr});
    // R5
    access_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_sel && !file_addr[FILE_W-1]) |-> phys_addr[ADDR_W-1:FILE_W] == '0);
    // R6
    access_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_sel && file_addr[FILE_W-1]) |-> phys_addr[ADDR_W-1:FILE_W] == '1);
    // R7
    sfr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_hit == (phys_addr >= ADDR_W'(SFR_BASE)));
endmodule

bind dmem_addr_former dmem_addr_former_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_wr    (bank_wr),
    .bank_wdata (bank_wdata),
    .file_addr  (file_addr),
    .bank_sel   (bank_sel),
    .phys_addr  (phys_addr),
    .sfr_hit    (sfr_hit),
    .bank_q     (bank_q)
);

// File: tb/test_dmem_addr_former.sv
module test_dmem_addr_former;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_wr = 1'b0;
    logic [7:0]  bank_wdata = '0;
    logic [7:0]  file_addr = '0;
    logic        bank_sel = 1'b0;
    logic [11:0] phys_addr;
    logic        sfr_hit;
    logic [7:0]  bank_q;

    int checks = 0;
    int errors = 0;
    logic [3:0] cur_bank = '0;

    always #4 clk = ~clk;

    dmem_addr_former i_dmem_addr_former (
        .clk(clk), .rst_n(rst_n), .bank_wr(bank_wr), .bank_wdata(bank_wdata),
        .file_addr(file_addr), .bank_sel(bank_sel), .phys_addr(phys_addr),
        .sfr_hit(sfr_hit), .bank_q(bank_q)
    );

    function automatic logic [11:0] exp_addr(logic [3:0] b, logic s, logic [7:0] f);
        if (s) return {b, f};
        return f[7] ? {4'hF, f} : {4'h0, f};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Load the bank register; the value is visible after the next edge (R2).
    task automatic load_bank(logic [7:0] v);
        @(negedge clk);
        bank_wr = 1'b1;
        bank_wdata = v;
        @(negedge clk);
        bank_wr = 1'b0;
        bank_wdata = $urandom;
        cur_bank = v[3:0];
        #1 chk("R2 bank readback", bank_q, {4'h0, v[3:0]});
    endtask

    // Apply an address combinationally and check address and flag (R4-R7, R9).
    task automatic probe(logic s, logic [7:0] f, string req);
        logic [11:0] e;
        file_addr = f;
        bank_sel = s;
        #1;
        e = exp_addr(cur_bank, s, f);
        chk(req, phys_addr, e);
        chk("R7 sfr flag", sfr_hit, e >= 12'hF80);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk("R1 reset bank", bank_q, 8'h00);

        // R3: no write, register holds through several cycles
        repeat (3) @(negedge clk);
        #1 chk("R3 hold", bank_q, 8'h00);

        // Sweep every bank, random upper nibble in the written literal
        for (int b = 0; b < 16; b++) begin
            load_bank({4'($urandom), 4'(b)});
            // R4 banked edges and random
            probe(1'b1, 8'h00, "R4 banked");
            probe(1'b1, 8'hFF, "R4 banked");
            probe(1'b1, 8'($urandom), "R4 banked");
            // R5/R6 access window unaffected by bank
            probe(1'b0, 8'h7F, "R5 access low");
            probe(1'b0, 8'h00, "R5 access low");
            probe(1'b0, 8'h80, "R6 access high");
            probe(1'b0, 8'($urandom), "R6/R5 access");
        end

        // R8: working register reachable both ways
        load_bank(8'hAF);
        probe(1'b1, 8'hE8, "R8 banked W");
        chk("R8 W addr", phys_addr, 12'hFE8);
        chk("R8 W flag", sfr_hit, 1'b1);
        probe(1'b0, 8'hE8, "R8 access W");
        chk("R8 W addr", phys_addr, 12'hFE8);
        // R7 edge just below the region
        probe(1'b1, 8'h7F, "R7 edge F7F");
        chk("R7 below", sfr_hit, 1'b0);

        // R9: load takes effect only after the edge
        @(negedge clk);
        bank_sel = 1'b1;
        file_addr = 8'h12;
        bank_wr = 1'b1;
        bank_wdata = 8'h03;
        #1 chk("R9 before edge", phys_addr, 12'hF12);
        @(negedge clk);
        bank_wr = 1'b0;
        cur_bank = 4'h3;
        #1 chk("R9 after edge", phys_addr, 12'h312);

        // Random mix
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 3) == 0) load_bank(8'($urandom));
            @(negedge clk);
            probe(1'($urandom), 8'($urandom), "R4/R5/R6 random");
        end

        // R1 again: reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cur_bank = '0;
        #1 chk("R1 re-reset", bank_q, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule